// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block fetches instruction bytes ahead of need. A fetch pointer walks through the instruction stream in sequential order. Whenever the execution side leaves the shared bus idle, the block asks for the next word of code. The returned bytes join a 16-byte ring. The decoder reads the oldest bytes through a peek window and then removes 1 to 4 of them in a single decode step. Opcodes, immediates and displacement bytes all come out of this one ring.

Each decode step may also push a decoded micro-operation into a three-entry FIFO. The execution unit takes entries from that FIFO with its own accept strobe. When the FIFO is full, the decoder is held off, so the byte ring stops draining. Prefetching carries on until the ring is full.

A taken jump raises the flush input together with a new address. The flush empties both queues and throws away any fetch that is still in flight. Fetching then restarts at the new address.

Top module: `fetch_ahead_unit`

## Requirements
- R1: After reset, validCount is 0 and uopValid is 0. With the execution side idle, the first request carries the address RESET_ADDR.
- R2: busReq is low in every cycle in which exeBusBusy or flushValid is high, so execution bus cycles always win.
- R3: A fetch counts as issued in a cycle with busReq and busGrant both high. Each issued fetch uses the address of the previous one plus 4. The first fetch after reset uses RESET_ADDR, and the first fetch after a flush uses flushAddr.
- R4: busReq is high exactly when the execution side is idle, no flush is present, no fetch is outstanding and validCount is at most 12. At most one fetch is outstanding at a time. The data returned with busRdValid is appended in the next cycle: byte k of the word (bits 8k+7:8k) is the byte at address A+k.
- R5: validCount gives the number of valid bytes in the ring, from 0 to 16. frontBytes bits 8i+7:8i hold the i-th oldest byte, for each i below validCount.
- R6: A decode step is accepted only when decValid and decReady are both high and 1 <= decBytes <= min(4, validCount). An accepted step removes decBytes bytes. A refused step removes nothing.
- R7: Micro-operations leave the FIFO in push order. uopData shows the oldest entry while uopValid is high. An entry is removed only in a cycle with uopAccept high.
- R8: decReady is low exactly when the FIFO holds 3 entries. While it is low, no bytes are drained, and prefetching still fills the ring up to 16 bytes.
- R9: flushValid empties both queues in the next cycle. If a fetch is outstanding, the data it returns later is dropped. Fetching resumes at flushAddr, and the first byte later shown at the front is the byte at flushAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| exeBusBusy | input | 1 | The execution side wants the bus in this cycle |
| busReq | output | 1 | Request to fetch a code word |
| busAddr | output | ADDR_W | Byte address of the requested word |
| busGrant | input | 1 | Arbiter accepts the request |
| busRdValid | input | 1 | Returned word is valid |
| busRdData | input | FETCH_BYTES*8 | Returned code bytes, lowest address in the low byte |
| flushValid | input | 1 | Empty the queues and redirect fetching |
| flushAddr | input | ADDR_W | New fetch address |
| validCount | output | CNT_W | Number of valid bytes in the ring |
| frontBytes | output | DEC_MAX*8 | Oldest bytes of the ring, oldest byte in the low byte |
| decValid | input | 1 | Decoder requests a decode step |
| decBytes | input | TAKE_W | Number of bytes to remove |
| decHasUop | input | 1 | The step also pushes decUop |
| decUop | input | UOP_W | Decoded micro-operation |
| decReady | output | 1 | The FIFO has room |
| uopValid | output | 1 | The FIFO holds at least one entry |
| uopData | output | UOP_W | Oldest micro-operation |
| uopAccept | input | 1 | Execution unit takes the oldest entry |

## Verification
The stimulus is random: bus grants arrive at random, return latency is random, execution-side bus use is random, and decode widths of 1 to 7 bytes are mixed with pops and rare flushes. Under this stimulus the unit is compared cycle by cycle with a bench-side model of both queues. Directed phases cover the remaining corners:
- A fill with no decoding separates the 12-byte request threshold from a full ring.
- Decoding into a FIFO that never drains shows that a refused push leaves the bytes in place.
- A flush raised while a fetch is in flight shows whether the stale word leaks into the ring.

// File: rtl/fetch_ahead_pkg.sv
package fetch_ahead_pkg;
  parameter int unsigned TAKE_W = 3;

  typedef struct packed {
    logic              flush;
    logic              fetchIssue;
    logic              fillWord;
    logic              consume;
    logic [TAKE_W-1:0] consumeCnt;
    logic              uopPush;
    logic              uopPop;
  } qStrobes_t;
endpackage

// File: rtl/fetch_ahead_ctrl.sv
module fetch_ahead_ctrl
  import fetch_ahead_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned QUEUE_BYTES = 16,
  parameter int unsigned FETCH_BYTES = 4,
  parameter int unsigned DEC_MAX     = 4,
  parameter int unsigned UOP_DEPTH   = 3,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int unsigned CNT_W  = $clog2(QUEUE_BYTES + 1),
  localparam int unsigned UCNT_W = $clog2(UOP_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              exeBusBusy,
  input  logic              busGrant,
  input  logic              busRdValid,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic              decValid,
  input  logic [TAKE_W-1:0] decBytes,
  input  logic              decHasUop,
  input  logic              uopAccept,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [UCNT_W-1:0] uopCount,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic              decReady,
  output logic              uopValid,
  output qStrobes_t         stb
);
  localparam logic [CNT_W-1:0]  ROOM_LIMIT = CNT_W'(QUEUE_BYTES - FETCH_BYTES);
  localparam logic [UCNT_W-1:0] UOP_FULL   = UCNT_W'(UOP_DEPTH);
  localparam logic [TAKE_W-1:0] TAKE_MAX   = TAKE_W'(DEC_MAX);
  localparam logic [ADDR_W-1:0] STRIDE     = ADDR_W'(FETCH_BYTES);

  logic [ADDR_W-1:0] fetchPtr;
  logic outstanding;
  logic discard;
  logic issue;
  logic stepOk;

  // Request only when the bus is free of execution traffic and a whole word fits.
  assign busReq   = !exeBusBusy && !flushValid && !outstanding && (byteCount <= ROOM_LIMIT);
  assign busAddr  = fetchPtr;
  assign issue    = busReq && busGrant;
  assign decReady = (uopCount != UOP_FULL);
  assign uopValid = (uopCount != '0);

  assign stepOk = decValid && decReady && (decBytes != '0) && (decBytes <= TAKE_MAX)
                  && (CNT_W'(decBytes) <= byteCount);

  always_comb begin
    stb            = '0;
    stb.flush      = flushValid;
    stb.fetchIssue = issue;
    stb.fillWord   = busRdValid && outstanding && !discard && !flushValid;
    stb.consume    = stepOk && !flushValid;
    stb.consumeCnt = decBytes;
    stb.uopPush    = stepOk && decHasUop && !flushValid;
    stb.uopPop     = uopValid && uopAccept && !flushValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchPtr    <= RESET_ADDR;
      outstanding <= 1'b0;
      discard     <= 1'b0;
    end else if (flushValid) begin
      fetchPtr    <= flushAddr;
      // a word still in flight must be swallowed when it lands
      outstanding <= outstanding && !busRdValid;
      discard     <= outstanding && !busRdValid;
    end else begin
      if (issue) fetchPtr <= fetchPtr + STRIDE;
      if (busRdValid && outstanding) begin
        outstanding <= 1'b0;
        discard     <= 1'b0;
      end else if (issue) begin
        outstanding <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fetch_ahead_dp.sv
module fetch_ahead_dp
  import fetch_ahead_pkg::*;
#(
  parameter int unsigned QUEUE_BYTES = 16,
  parameter int unsigned FETCH_BYTES = 4,
  parameter int unsigned DEC_MAX     = 4,
  parameter int unsigned UOP_DEPTH   = 3,
  parameter int unsigned UOP_W       = 32,
  localparam int unsigned CNT_W  = $clog2(QUEUE_BYTES + 1),
  localparam int unsigned IDX_W  = $clog2(QUEUE_BYTES),
  localparam int unsigned UCNT_W = $clog2(UOP_DEPTH + 1),
  localparam int unsigned UIDX_W = $clog2(UOP_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  qStrobes_t                stb,
  input  logic [FETCH_BYTES*8-1:0] fillData,
  input  logic [UOP_W-1:0]         uopIn,
  output logic [CNT_W-1:0]         byteCount,
  output logic [DEC_MAX*8-1:0]     frontBytes,
  output logic [UCNT_W-1:0]        uopCount,
  output logic [UOP_W-1:0]         uopHead
);
  localparam logic [UIDX_W-1:0] ULAST = UIDX_W'(UOP_DEPTH - 1);

  // byte ring: power-of-two depth, indices wrap naturally
  logic [7:0]       slots [QUEUE_BYTES];
  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] wrIdx;

  always_ff @(posedge clk) begin
    if (stb.fillWord) begin
      for (int k = 0; k < FETCH_BYTES; k++) begin
        slots[IDX_W'(int'(wrIdx) + k)] <= fillData[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx     <= '0;
      wrIdx     <= '0;
      byteCount <= '0;
    end else if (stb.flush) begin
      rdIdx     <= '0;
      wrIdx     <= '0;
      byteCount <= '0;
    end else begin
      if (stb.fillWord) wrIdx <= wrIdx + IDX_W'(FETCH_BYTES);
      if (stb.consume)  rdIdx <= rdIdx + IDX_W'(stb.consumeCnt);
      byteCount <= byteCount
                 + (stb.fillWord ? CNT_W'(FETCH_BYTES) : '0)
                 - (stb.consume  ? CNT_W'(stb.consumeCnt) : '0);
    end
  end

  generate
    for (genvar i = 0; i < DEC_MAX; i++) begin : g_peek
      assign frontBytes[8*i +: 8] = slots[IDX_W'(int'(rdIdx) + i)];
    end
  endgenerate

  // decoded micro-op FIFO: arbitrary depth, explicit wrap
  logic [UOP_W-1:0]  uopMem [UOP_DEPTH];
  logic [UIDX_W-1:0] uRd;
  logic [UIDX_W-1:0] uWr;

  always_ff @(posedge clk) begin
    if (stb.uopPush) uopMem[uWr] <= uopIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uRd      <= '0;
      uWr      <= '0;
      uopCount <= '0;
    end else if (stb.flush) begin
      uRd      <= '0;
      uWr      <= '0;
      uopCount <= '0;
    end else begin
      if (stb.uopPush) uWr <= (uWr == ULAST) ? '0 : uWr + 1'b1;
      if (stb.uopPop)  uRd <= (uRd == ULAST) ? '0 : uRd + 1'b1;
      uopCount <= uopCount + UCNT_W'(stb.uopPush) - UCNT_W'(stb.uopPop);
    end
  end

  assign uopHead = uopMem[uRd];
endmodule

// File: rtl/fetch_ahead_unit.sv
module fetch_ahead_unit
  import fetch_ahead_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned QUEUE_BYTES = 16,
  parameter int unsigned FETCH_BYTES = 4,
  parameter int unsigned DEC_MAX     = 4,
  parameter int unsigned UOP_DEPTH   = 3,
  parameter int unsigned UOP_W       = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_FFF0,
  localparam int unsigned CNT_W  = $clog2(QUEUE_BYTES + 1),
  localparam int unsigned UCNT_W = $clog2(UOP_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     exeBusBusy,
  output logic                     busReq,
  output logic [ADDR_W-1:0]        busAddr,
  input  logic                     busGrant,
  input  logic                     busRdValid,
  input  logic [FETCH_BYTES*8-1:0] busRdData,
  input  logic                     flushValid,
  input  logic [ADDR_W-1:0]        flushAddr,
  output logic [CNT_W-1:0]         validCount,
  output logic [DEC_MAX*8-1:0]     frontBytes,
  input  logic                     decValid,
  input  logic [TAKE_W-1:0]        decBytes,
  input  logic                     decHasUop,
  input  logic [UOP_W-1:0]         decUop,
  output logic                     decReady,
  output logic                     uopValid,
  output logic [UOP_W-1:0]         uopData,
  input  logic                     uopAccept
);
  qStrobes_t         stb;
  logic [UCNT_W-1:0] uopCount;

  fetch_ahead_ctrl #(
    .ADDR_W(ADDR_W), .QUEUE_BYTES(QUEUE_BYTES), .FETCH_BYTES(FETCH_BYTES),
    .DEC_MAX(DEC_MAX), .UOP_DEPTH(UOP_DEPTH), .RESET_ADDR(RESET_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .exeBusBusy(exeBusBusy), .busGrant(busGrant),
    .busRdValid(busRdValid), .flushValid(flushValid), .flushAddr(flushAddr),
    .decValid(decValid), .decBytes(decBytes), .decHasUop(decHasUop),
    .uopAccept(uopAccept), .byteCount(validCount), .uopCount(uopCount),
    .busReq(busReq), .busAddr(busAddr), .decReady(decReady),
    .uopValid(uopValid), .stb(stb)
  );

  fetch_ahead_dp #(
    .QUEUE_BYTES(QUEUE_BYTES), .FETCH_BYTES(FETCH_BYTES), .DEC_MAX(DEC_MAX),
    .UOP_DEPTH(UOP_DEPTH), .UOP_W(UOP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .fillData(busRdData), .uopIn(decUop),
    .byteCount(validCount), .frontBytes(frontBytes), .uopCount(uopCount),
    .uopHead(uopData)
  );
endmodule

// File: rtl/fetch_ahead_checker.sv
module fetch_ahead_checker #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned QUEUE_BYTES = 16,
  parameter int unsigned FETCH_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int unsigned CNT_W = $clog2(QUEUE_BYTES + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              exeBusBusy,
  input logic              flushValid,
  input logic [ADDR_W-1:0] flushAddr,
  input logic              busReq,
  input logic              busGrant,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRdValid,
  input logic [CNT_W-1:0]  validCount,
  input logic              uopValid
);
  logic [ADDR_W-1:0] expAddr;
  logic              inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expAddr  <= RESET_ADDR;
      inFlight <= 1'b0;
    end else begin
      if (flushValid) expAddr <= flushAddr;
      else if (busReq && busGrant) expAddr <= busAddr + ADDR_W'(FETCH_BYTES);
      if (busReq && busGrant) inFlight <= 1'b1;
      else if (busRdValid) inFlight <= 1'b0;
    end
  end

  // R2
  a_r2_exe_priority: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (!exeBusBusy && !flushValid));
  // R3
  a_r3_sequential: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busAddr == expAddr));
  // R4
  a_r4_room: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (validCount <= CNT_W'(QUEUE_BYTES - FETCH_BYTES)));
  // R4
  a_r4_single: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !inFlight);
  // R5
  a_r5_bound: assert property (@(posedge clk) disable iff (!rstN)
    validCount <= CNT_W'(QUEUE_BYTES));
  // R9
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> (validCount == '0 && !uopValid));
endmodule

bind fetch_ahead_unit fetch_ahead_checker #(
  .ADDR_W(ADDR_W), .QUEUE_BYTES(QUEUE_BYTES), .FETCH_BYTES(FETCH_BYTES),
  .RESET_ADDR(RESET_ADDR)
) u_checker (
  .clk(clk), .rstN(rstN), .exeBusBusy(exeBusBusy), .flushValid(flushValid),
  .flushAddr(flushAddr), .busReq(busReq), .busGrant(busGrant), .busAddr(busAddr),
  .busRdValid(busRdValid), .validCount(validCount), .uopValid(uopValid)
);

// File: tb/fetch_ahead_unit_bench.sv
module fetch_ahead_unit_bench;
  localparam logic [31:0] RST_A = 32'h0000_FFF0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic exeBusBusy = 0, busGrant = 0, busRdValid = 0, flushValid = 0;
  logic decValid = 0, decHasUop = 0, uopAccept = 0;
  logic [31:0] flushAddr = '0, busRdData = '0, decUop = '0;
  logic [2:0] decBytes = '0;
  logic busReq, decReady, uopValid;
  logic [31:0] busAddr, frontBytes, uopData;
  logic [4:0] validCount;

  fetch_ahead_unit #(.RESET_ADDR(RST_A)) u_fetch_ahead_unit (
    .clk(clk), .rstN(rstN), .exeBusBusy(exeBusBusy), .busReq(busReq),
    .busAddr(busAddr), .busGrant(busGrant), .busRdValid(busRdValid),
    .busRdData(busRdData), .flushValid(flushValid), .flushAddr(flushAddr),
    .validCount(validCount), .frontBytes(frontBytes), .decValid(decValid),
    .decBytes(decBytes), .decHasUop(decHasUop), .decUop(decUop),
    .decReady(decReady), .uopValid(uopValid), .uopData(uopData),
    .uopAccept(uopAccept)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  // stimulus knobs, percent
  int pExe = 0, pGrant = 100, pDec = 0, pAcc = 0, pFlush = 0, pHu = 50;
  int maxN = 4;

  // model state
  int mCount;
  int mUopN;
  logic [31:0] mFront, mFetch;
  logic [31:0] mUop [3];
  bit mOut, mDisc, refusedLast;
  bit rBusy;
  int rTimer;
  logic [31:0] rAddr;

  function automatic logic [7:0] memByte(logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] memWord(logic [31:0] a);
    return {memByte(a + 3), memByte(a + 2), memByte(a + 1), memByte(a)};
  endfunction

  function automatic void chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  task automatic step();
    bit exe, gr, fl, dv, hu, acc, rv, expReq, accept, pop;
    int n;
    logic [31:0] fa;
    @(negedge clk);
    exe = ($urandom % 100) < pExe;
    gr  = ($urandom % 100) < pGrant;
    fl  = ($urandom % 100) < pFlush;
    dv  = ($urandom % 100) < pDec;
    acc = ($urandom % 100) < pAcc;
    hu  = ($urandom % 100) < pHu;
    n   = 1 + ($urandom % maxN);
    fa  = $urandom;
    rv  = rBusy && (rTimer == 0);
    exeBusBusy = exe; busGrant = gr; flushValid = fl; flushAddr = fa;
    decValid = dv; decBytes = 3'(n); decHasUop = hu; decUop = $urandom;
    uopAccept = acc; busRdValid = rv;
    busRdData = rv ? memWord(rAddr) : $urandom;
    #1;
    expReq = !exe && !fl && !mOut && (mCount <= 12);
    chk(busReq == expReq, (exe || fl) ? "R2" : "R4", "busReq", busReq, expReq);
    if (busReq && expReq) chk(busAddr == mFetch, "R3", "busAddr", busAddr, mFetch);
    chk(validCount == mCount, refusedLast ? "R6" : "R5", "validCount", validCount, mCount);
    for (int i = 0; i < 4; i++)
      if (i < mCount)
        chk(frontBytes[8*i +: 8] == memByte(mFront + i), "R5", "frontByte",
            frontBytes[8*i +: 8], memByte(mFront + i));
    chk(decReady == (mUopN < 3), "R8", "decReady", decReady, mUopN < 3);
    chk(uopValid == (mUopN != 0), "R7", "uopValid", uopValid, mUopN != 0);
    if (mUopN != 0) chk(uopData == mUop[0], "R7", "uopData", uopData, mUop[0]);

    // model update for the coming edge
    accept = dv && (mUopN < 3) && (n <= 4) && (n <= mCount);
    refusedLast = dv && !accept && !fl;
    if (fl) begin
      if (rv) begin mOut = 0; mDisc = 0; end
      else if (mOut) mDisc = 1;
      mCount = 0; mUopN = 0; mFront = fa; mFetch = fa;
    end else begin
      pop = (mUopN != 0) && acc;
      if (accept) begin mCount -= n; mFront += n; end
      if (rv && mOut) begin
        if (!mDisc) mCount += 4;
        mOut = 0; mDisc = 0;
      end
      if (pop) begin
        mUop[0] = mUop[1]; mUop[1] = mUop[2]; mUopN--;
      end
      if (accept && hu) begin mUop[mUopN] = decUop; mUopN++; end
    end
    if (rv) rBusy = 0;
    else if (rBusy) rTimer--;
    if (busReq && gr) begin
      mOut = 1; rBusy = 1; rAddr = mFetch; rTimer = $urandom % 4;
      mFetch += 4;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic [31:0] flA;
    void'($urandom(32'd4242));
    mCount = 0; mUopN = 0; mFront = RST_A; mFetch = RST_A;
    mOut = 0; mDisc = 0; rBusy = 0; rTimer = 0; refusedLast = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1 reset state
    chk(validCount == 0, "R1", "validCount", validCount, 0);
    chk(uopValid == 0, "R1", "uopValid", uopValid, 0);
    chk(busReq == 1 && busAddr == RST_A, "R1", "first address", busAddr, RST_A);

    // R4: fill without decoding, ring reaches 16 and requests stop
    repeat (40) step();
    chk(validCount == 16, "R4", "full ring", validCount, 16);
    chk(busReq == 0, "R4", "no request when full", busReq, 0);

    // R6: oversize and over-count steps are refused
    pDec = 100; maxN = 7; pGrant = 0; pFlush = 100; step(); pFlush = 0;
    repeat (6) step();
    chk(validCount == 0, "R6", "empty ring refuses", validCount, 0);
    pGrant = 100; repeat (60) step();

    // R8: FIFO never drains, bytes stay, prefetch fills
    pAcc = 0; pHu = 100; maxN = 4; repeat (60) step();
    chk(decReady == 0, "R8", "decReady full", decReady, 0);
    chk(validCount == 16, "R8", "ring fills while blocked", validCount, 16);
    // R7: drain in order
    pDec = 0; pAcc = 100; repeat (6) step();
    chk(uopValid == 0, "R7", "drained", uopValid, 0);

    // R9: flush while a fetch is in flight
    pAcc = 0; pFlush = 100; pGrant = 0; step(); pFlush = 0;
    pGrant = 100; step();
    while (!(mOut && rTimer > 0)) step();
    pFlush = 100; step(); pFlush = 0;
    flA = mFront;
    #1;
    chk(validCount == 0 && uopValid == 0, "R9", "flush empties", validCount, 0);
    repeat (12) step();
    #1;
    chk(validCount >= 4, "R9", "refill", validCount, 4);
    chk(frontBytes[7:0] == memByte(flA), "R9", "resume byte", frontBytes[7:0], memByte(flA));

    // random mix
    for (int blk = 0; blk < 30; blk++) begin
      pExe = $urandom % 60; pGrant = 20 + $urandom % 80; pDec = $urandom % 100;
      pAcc = $urandom % 100; pFlush = $urandom % 4; pHu = $urandom % 100;
      maxN = 4 + $urandom % 4;
      repeat (150) step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule